// File: doc/BRIEF.md
# Keyed Watchdog Timer

A watchdog peripheral that sits on a simple word-addressed register bus in the interconnect clock domain. Its counter advances on a slow tick strobe (nominally 32 kHz, given as a one-cycle enable in the same clock domain), optionally divided by a power-of-two prescaler. The counter counts upward. When it rolls over from all ones, the block raises a one-cycle reset request and starts again from the load value.

Host writes to the control, load, trigger and arming registers are posted. Each write is held in a shadow register, and a pending flag stays set until the next slow tick applies it. A write to a register whose flag is still set is dropped, so software must poll the pending register first. Start and stop each need an ordered pair of key words. A keepalive reloads the counter only when the trigger word differs from the previous one, so software alternates a value and its complement.

The bus never stalls: `bus_ready` is tied high, every beat with `bus_valid` high is taken on that edge, and read data is valid in the same cycle as the request. There is no back-pressure to honour on either side.

Top module: `wdg_timer`

## Requirements
- R1: After reset the counter is running, the load value, the control value, the counter and the last trigger word are zero, no pending flag is set, and word address 0 returns the REVISION parameter in bits 7:0.
- R2: A write to control (address 1), load (3), trigger (4) or arm (5) sets pending bit 0, 2, 3 or 4 respectively in the pending register (address 6). The bit clears at the next tick, and the value takes effect at that same tick.
- R3: A write to a register whose pending bit is set is dropped, and the earlier posted value is the one applied.
- R4: Arm words 0xBBBB then 0x4444, applied one after the other, start the counter.
- R5: Arm words 0xAAAA then 0x5555, applied one after the other, stop the counter, and it then holds its value across ticks.
- R6: If a second key word is not applied directly after its matching first word, the pair is ignored and the run state is unchanged.
- R7: An applied trigger word that differs from the last applied trigger word loads the counter (address 2) from the load value. That tick does not also count.
- R8: An applied trigger word equal to the last applied trigger word causes no reload.
- R9: Control bit 5 enables the prescaler and bits 4:2 hold an exponent E. When the prescaler is enabled, the counter steps once per 2^E ticks, counted from the tick that applied the control write. When it is disabled, the counter steps on every tick.
- R10: A step taken from all ones raises `wd_reset_req` for exactly one cycle and loads the counter from the load value.
- R11: `bus_ready` is always high, and read data is returned in the same cycle as the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Slow time-base strobe, one cycle wide |
| bus_valid | input | 1 | Bus request valid |
| bus_ready | output | 1 | Bus request accepted (always high) |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| wd_reset_req | output | 1 | One-cycle reset request on counter rollover |

## Verification
The prescaler is driven from a table of control words: prescaler disabled, enabled with exponent 0, enabled with exponents 1 to 3, and an exponent with the enable bit clear. These rows separate the enable bit from the exponent field and detect an off-by-one in the divide mask. The key sequences are applied in order, with a foreign word inserted between the two halves, and with a crossed pair (start first word, stop first word, start second word). This separates real sequence tracking from simple word matching. Trigger writes are applied as repeated values and as complemented values, to show that a reload depends on the word changing. A load near all ones is used to reach the rollover edge.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int ADDR_W = 3;
  localparam int PEND_W = 5;
  localparam int EXP_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_REV   = 3'd0,
    A_CTRL  = 3'd1,
    A_COUNT = 3'd2,
    A_LOAD  = 3'd3,
    A_TRIG  = 3'd4,
    A_ARM   = 3'd5,
    A_PEND  = 3'd6
  } reg_addr_e;

  localparam int PB_CTRL = 0;
  localparam int PB_LOAD = 2;
  localparam int PB_TRIG = 3;
  localparam int PB_ARM  = 4;

  localparam int CTRL_EN_BIT  = 5;
  localparam int CTRL_EXP_LSB = 2;
  localparam int CTRL_W       = EXP_W + 1;

  localparam logic [15:0] KEY_ON_A  = 16'hBBBB;
  localparam logic [15:0] KEY_ON_B  = 16'h4444;
  localparam logic [15:0] KEY_OFF_A = 16'hAAAA;
  localparam logic [15:0] KEY_OFF_B = 16'h5555;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ON_HALF = 2'd1,
    SEQ_OFF_HALF = 2'd2
  } seq_e;
endpackage

// File: rtl/wdg_bus_regs.sv
module wdg_bus_regs
  import wdg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int REVISION = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [CNT_W-1:0]  count,
  output logic [PEND_W-1:0] pend,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              ctrl_apply,
  output logic [CNT_W-1:0]  load_next,
  output logic              reload,
  output logic              arm_apply,
  output logic [15:0]       arm_word
);
  logic              wr;
  logic [PEND_W-1:0] hit;
  logic [PEND_W-1:0] take;
  logic [PEND_W-1:0] app;
  logic [CTRL_W-1:0] ctrl_sh;
  logic [CNT_W-1:0]  load_sh, load_q;
  logic [DATA_W-1:0] trig_sh, last_trig;
  logic [15:0]       arm_sh;

  assign wr = bus_valid && bus_write;

  always_comb begin
    hit          = '0;
    hit[PB_CTRL] = wr && (bus_addr == A_CTRL);
    hit[PB_LOAD] = wr && (bus_addr == A_LOAD);
    hit[PB_TRIG] = wr && (bus_addr == A_TRIG);
    hit[PB_ARM]  = wr && (bus_addr == A_ARM);
  end

  for (genvar i = 0; i < PEND_W; i++) begin : g_pend
    assign take[i] = hit[i] && !pend[i];
    assign app[i]  = pend[i] && tick;
    always_ff @(posedge clk) begin
      if (!rst_n)      pend[i] <= 1'b0;
      else if (app[i]) pend[i] <= 1'b0;
      else if (hit[i]) pend[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_sh <= '0;
      load_sh <= '0;
      trig_sh <= '0;
      arm_sh  <= '0;
    end else begin
      if (take[PB_CTRL]) ctrl_sh <= bus_wdata[CTRL_EN_BIT:CTRL_EXP_LSB];
      if (take[PB_LOAD]) load_sh <= bus_wdata[CNT_W-1:0];
      if (take[PB_TRIG]) trig_sh <= bus_wdata;
      if (take[PB_ARM])  arm_sh  <= bus_wdata[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      load_q    <= '0;
      last_trig <= '0;
    end else begin
      if (app[PB_CTRL]) ctrl_q    <= ctrl_sh;
      if (app[PB_LOAD]) load_q    <= load_sh;
      if (app[PB_TRIG]) last_trig <= trig_sh;
    end
  end

  assign ctrl_apply = app[PB_CTRL];
  assign load_next  = app[PB_LOAD] ? load_sh : load_q;
  assign reload     = app[PB_TRIG] && (trig_sh != last_trig);
  assign arm_apply  = app[PB_ARM];
  assign arm_word   = arm_sh;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_REV:   bus_rdata[7:0] = 8'(REVISION);
      A_CTRL:  bus_rdata[CTRL_EN_BIT:CTRL_EXP_LSB] = ctrl_q;
      A_COUNT: bus_rdata[CNT_W-1:0] = count;
      A_LOAD:  bus_rdata[CNT_W-1:0] = load_q;
      A_TRIG:  bus_rdata = last_trig;
      A_PEND:  bus_rdata[PEND_W-1:0] = pend;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/wdg_arm_seq.sv
module wdg_arm_seq
  import wdg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        arm_apply,
  input  logic [15:0] arm_word,
  output logic        running
);
  seq_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SEQ_IDLE;
      running <= 1'b1;
    end else if (arm_apply) begin
      if (arm_word == KEY_ON_A) begin
        st <= SEQ_ON_HALF;
      end else if (arm_word == KEY_OFF_A) begin
        st <= SEQ_OFF_HALF;
      end else if (st == SEQ_ON_HALF && arm_word == KEY_ON_B) begin
        running <= 1'b1;
        st      <= SEQ_IDLE;
      end else if (st == SEQ_OFF_HALF && arm_word == KEY_OFF_B) begin
        running <= 1'b0;
        st      <= SEQ_IDLE;
      end else begin
        st <= SEQ_IDLE;
      end
    end
  end
endmodule

// File: rtl/wdg_prescale.sv
module wdg_prescale
  import wdg_pkg::*;
#(
  parameter int XW = EXP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clear,
  input  logic          en,
  input  logic [XW-1:0] expo,
  output logic          step
);
  localparam int DIV_W = (1 << XW) - 1;

  logic [DIV_W-1:0] pcnt;
  logic [DIV_W-1:0] mask;

  assign mask = (DIV_W'(1) << expo) - DIV_W'(1);
  assign step = tick && !clear && (!en || ((pcnt & mask) == mask));

  always_ff @(posedge clk) begin
    if (!rst_n)           pcnt <= '0;
    else if (clear)       pcnt <= '0;
    else if (tick && en)  pcnt <= pcnt + DIV_W'(1);
  end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             running,
  input  logic             reload,
  input  logic [CNT_W-1:0] load_next,
  output logic [CNT_W-1:0] count,
  output logic             wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      wrap  <= 1'b0;
    end else begin
      wrap <= 1'b0;
      if (reload) begin
        count <= load_next;
      end else if (running && step) begin
        if (&count) begin
          count <= load_next;
          wrap  <= 1'b1;
        end else begin
          count <= count + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
  import wdg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 32,
  parameter int REVISION = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_valid,
  output logic              bus_ready,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wd_reset_req
);
  logic [PEND_W-1:0] pend;
  logic [CTRL_W-1:0] ctrl_q;
  logic              ctrl_apply;
  logic [CNT_W-1:0]  load_next;
  logic              reload;
  logic              arm_apply;
  logic [15:0]       arm_word;
  logic              running;
  logic              step;
  logic [CNT_W-1:0]  count;

  assign bus_ready = 1'b1;

  wdg_bus_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .REVISION(REVISION)) u_regs (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .count(count),
    .pend(pend), .ctrl_q(ctrl_q), .ctrl_apply(ctrl_apply),
    .load_next(load_next), .reload(reload),
    .arm_apply(arm_apply), .arm_word(arm_word)
  );

  wdg_arm_seq u_arm (
    .clk(clk), .rst_n(rst_n), .arm_apply(arm_apply), .arm_word(arm_word),
    .running(running)
  );

  wdg_prescale #(.XW(EXP_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clear(ctrl_apply),
    .en(ctrl_q[CTRL_W-1]), .expo(ctrl_q[EXP_W-1:0]), .step(step)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .running(running),
    .reload(reload), .load_next(load_next), .count(count),
    .wrap(wd_reset_req)
  );
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk
  import wdg_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [PEND_W-1:0] pend,
  input logic              running,
  input logic              step,
  input logic              reload,
  input logic [CNT_W-1:0]  load_next,
  input logic [CNT_W-1:0]  count,
  input logic              wd_reset_req
);
  AST_PEND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[PB_TRIG] && tick) |=> !pend[PB_TRIG]); // R2

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[PB_LOAD] && !tick && bus_valid && bus_write && bus_addr == A_LOAD) |=> pend[PB_LOAD]); // R3

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reload) |=> $stable(count)); // R5

  AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (count == $past(load_next))); // R7

  AST_STEP_ADDS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && step && !reload && !(&count)) |=> (count == $past(count) + CNT_W'(1))); // R9

  AST_WRAP_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (running && step && !reload && (&count)) |=> (wd_reset_req && count == $past(load_next))); // R10

  AST_WRAP_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset_req) |-> $past(step)); // R10
endmodule

bind wdg_timer wdg_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
  .bus_write(bus_write), .bus_addr(bus_addr), .pend(pend),
  .running(running), .step(step), .reload(reload), .load_next(load_next),
  .count(count), .wd_reset_req(wd_reset_req)
);

// File: tb/wdg_timer_tb.sv
`timescale 1ns/1ps
module wdg_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_ready;
  logic        bus_write = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_reset_req;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  wdg_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wd_reset_req(wd_reset_req)
  );

  // {control word, ticks applied, expected counter advance}
  localparam logic [23:0] PRE_VEC [6] = '{
    {8'h00, 8'd8,  8'd8},
    {8'h20, 8'd8,  8'd8},
    {8'h24, 8'd8,  8'd4},
    {8'h28, 8'd8,  8'd2},
    {8'h2C, 8'd16, 8'd2},
    {8'h04, 8'd6,  8'd6}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  task automatic pulse();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic settle();
    logic [31:0] p;
    rd(3'd6, p);
    for (int k = 0; k < 4 && p != 0; k++) begin
      pulse();
      rd(3'd6, p);
    end
  endtask

  task automatic post(input logic [2:0] a, input logic [31:0] d);
    wr(a, d);
    settle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [31:0] v, c0, c1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); check("R1 revision", v, 32'h21);
    rd(3'd1, v); check("R1 ctrl", v, 0);
    rd(3'd3, v); check("R1 load", v, 0);
    rd(3'd6, v); check("R1 pending", v, 0);
    rd(3'd2, v); check("R1 count", v, 0);
    pulse();
    rd(3'd2, v); check("R1 running after reset", v, 1);
    check("R11 ready", {31'd0, bus_ready}, 1);

    // R2 posted write to load: bit 2 pending until tick
    wr(3'd3, 32'h100);
    rd(3'd6, v); check("R2 load pending bit2", v, 32'h04);
    rd(3'd3, v); check("R2 load not yet applied", v, 0);
    pulse();
    rd(3'd6, v); check("R2 pending cleared", v, 0);
    rd(3'd3, v); check("R2 load applied", v, 32'h100);

    // R3 second write while pending dropped
    wr(3'd3, 32'h200);
    wr(3'd3, 32'h300);
    pulse();
    rd(3'd3, v); check("R3 dropped write", v, 32'h200);
    wr(3'd4, 32'h1234);
    rd(3'd6, v); check("R2 trig pending bit3", v, 32'h08);

    // R7 new trigger word reloads
    pulse();
    rd(3'd2, v); check("R7 reload", v, 32'h200);
    repeat (3) pulse();
    rd(3'd2, v); check("R9 steps after reload", v, 32'h203);

    // R8 same word: no reload
    post(3'd4, 32'h1234);
    rd(3'd2, v); check("R8 repeated trigger", v, 32'h204);
    wr(3'd4, 32'hFFFF_EDCB);
    pulse();
    rd(3'd2, v); check("R7 complement reloads", v, 32'h200);

    // R5 stop
    wr(3'd5, 32'hAAAA);
    rd(3'd6, v); check("R2 arm pending bit4", v, 32'h10);
    pulse();
    post(3'd5, 32'h5555);
    rd(3'd2, c0);
    repeat (3) pulse();
    rd(3'd2, c1); check("R5 stopped holds", c1, c0);

    // R6 broken sequences
    post(3'd5, 32'hBBBB); post(3'd5, 32'h1111); post(3'd5, 32'h4444);
    repeat (2) pulse();
    rd(3'd2, v); check("R6 foreign word between", v, c0);
    post(3'd5, 32'hBBBB); post(3'd5, 32'hAAAA); post(3'd5, 32'h4444);
    repeat (2) pulse();
    rd(3'd2, v); check("R6 crossed pair", v, c0);

    // R4 start
    post(3'd5, 32'hBBBB); post(3'd5, 32'h4444);
    rd(3'd2, c0);
    repeat (2) pulse();
    rd(3'd2, v); check("R4 started", v, c0 + 2);

    // R9 prescaler table
    for (int i = 0; i < 6; i++) begin
      post(3'd1, {24'd0, PRE_VEC[i][23:16]});
      rd(3'd1, v); check("R9 ctrl readback", v, {24'd0, PRE_VEC[i][23:16] & 8'h3C});
      rd(3'd2, c0);
      for (int t = 0; t < int'(PRE_VEC[i][15:8]); t++) pulse();
      rd(3'd2, c1); check("R9 prescale advance", c1 - c0, {24'd0, PRE_VEC[i][7:0]});
    end

    // R10 rollover
    post(3'd1, 32'h0);
    post(3'd3, 32'hFFFF_FFFE);
    wr(3'd4, 32'h1);
    pulse();
    rd(3'd2, v); check("R7 reload near top", v, 32'hFFFF_FFFE);
    wr(3'd3, 32'h50);
    pulse();
    rd(3'd2, v); check("R9 at all ones", v, 32'hFFFF_FFFF);
    check("R10 no early request", {31'd0, wd_reset_req}, 0);
    pulse();
    check("R10 request raised", {31'd0, wd_reset_req}, 1);
    rd(3'd2, v); check("R10 reload after wrap", v, 32'h50);
    check("R10 single cycle", {31'd0, wd_reset_req}, 0);
    check("R11 ready", {31'd0, bus_ready}, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule